// File: doc/BRIEF.md
# Instruction Cache Invalidation Walker

This block clears a small read-only instruction cache in response to a single invalidate request. The request arrives from one of two sources: a kernel-launch event raised by a compute unit, or an explicit invalidate instruction. The walker does not flash-clear the valid bits. It visits every block index in turn and hands one eviction per index to the cache controller through a ready/valid issue port. A pending counter rises by one for each eviction the controller accepts and falls by one for each eviction-done report. The single completion response is held back until every index has been issued and the counter has drained back to zero.

While an invalidate is in flight, the block accepts no further invalidate and refuses all instruction fetch lookups, so no line can be refilled behind the walker. Several compute units share one cache. For that reason, a kernel-launch invalidate takes effect only when it comes from the first unit of its group. Launch requests from the other units are consumed silently. The block also holds the per-line state array. Lookups move lines toward pending-fill, fills complete them, and eviction-done reports return them to Invalid. Evictions raise neither a hit pulse nor a miss pulse.

Top module: `icinv_walker`

## Requirements
- R1: After reset the block is idle: `inv_req_ready` and `fetch_ready` are 1, `ev_issue_valid` and `inv_rsp_valid` are 0, and every line reads Invalid (state code 2'b00).
- R2: Once an invalidate is accepted, `inv_req_ready` stays 0 until the cycle after its response is taken (`inv_rsp_valid` and `inv_rsp_ready` both 1). At most one invalidate is in progress at a time.
- R3: An accepted walk issues exactly NUM_BLOCKS evictions, one per index, in increasing order from 0 to NUM_BLOCKS-1. The first issue appears in the cycle after acceptance.
- R4: While `ev_issue_ready` is 0, the walker holds `ev_issue_valid` high with an unchanged `ev_issue_idx`. Only accepted issues count as pending.
- R5: `inv_rsp_valid` rises exactly two cycles after the cycle that carries the final eviction-done report, and only after all evictions have been issued. It stays high until `inv_rsp_ready`. It returns the request's `id` and source.
- R6: An eviction-done report sets the named line to Invalid from Invalid, pending-fill (2'b01) or Valid (2'b10). This has priority over a fill in the same cycle, and it produces no hit or miss pulse.
- R7: `fetch_ready` is 0 from the cycle after acceptance of a walking invalidate until the cycle after its response is taken.
- R8: An accepted lookup produces one registered pulse in the next cycle: `fetch_hit` if the line was Valid, `fetch_miss` otherwise. A lookup on an Invalid line makes it pending-fill. A fill changes only a pending-fill line, making it Valid.
- R9: A kernel-launch request (`inv_req_src`=0) from a unit whose index modulo UNITS_PER_GROUP is not 0 is accepted and dropped, with no walk and no response. An instruction request (`inv_req_src`=1) walks from any unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_req_valid | input | 1 | Invalidate request present |
| inv_req_ready | output | 1 | Block can accept an invalidate |
| inv_req_src | input | 1 | 0 kernel launch, 1 explicit instruction |
| inv_req_unit | input | UNIT_W | Index of the requesting compute unit |
| inv_req_id | input | ID_W | Tag returned with the response |
| inv_rsp_valid | output | 1 | Completion response present |
| inv_rsp_ready | input | 1 | Response taken |
| inv_rsp_id | output | ID_W | Tag of the completed request |
| inv_rsp_src | output | 1 | Source of the completed request |
| ev_issue_valid | output | 1 | Eviction offered to the cache controller |
| ev_issue_ready | input | 1 | Controller queue accepts the eviction |
| ev_issue_idx | output | IDX_W | Block index to evict |
| ev_done_valid | input | 1 | One eviction has finished |
| ev_done_idx | input | IDX_W | Index of the finished eviction |
| fetch_valid | input | 1 | Instruction lookup request |
| fetch_ready | output | 1 | Lookup accepted (0 during a walk) |
| fetch_idx | input | IDX_W | Line index of the lookup |
| fetch_hit | output | 1 | Pulse: lookup found a Valid line |
| fetch_miss | output | 1 | Pulse: lookup found a non-Valid line |
| fill_valid | input | 1 | Refill data arrived for a line |
| fill_idx | input | IDX_W | Line index of the fill |
| query_idx | input | IDX_W | Line index to observe |
| query_state | output | 2 | State code of the observed line |

## Verification
The walk is run three ways:
- with a controller that accepts every cycle and returns completions promptly;
- with a controller that accepts only every third cycle and completes slowly;
- with a held-off response consumer.

The first run shows index order and the exact response delay. The second shows that the walker holds an index under back-pressure, and that the response waits for the pending count to drain rather than for the last issue. The third shows that the response and its tag persist. Kernel-launch requests from a group leader and from a non-leader unit tell apart a real walk from a silent drop. Lookups and fills placed before and during a walk, on Invalid, pending-fill and Valid lines, separate hit from miss and show that an eviction overrides a late fill.

// File: rtl/icinv_pkg.sv
package icinv_pkg;

    typedef enum logic [1:0] {
        LN_INV   = 2'b00,
        LN_FILL  = 2'b01,
        LN_VALID = 2'b10
    } line_st_e;

    typedef enum logic {
        SRC_LAUNCH = 1'b0,
        SRC_INSTR  = 1'b1
    } inv_src_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_ISSUE,
        WK_DRAIN,
        WK_REPLY
    } walk_st_e;

    function automatic logic walk_needed(input logic src,
                                         input int unsigned unit,
                                         input int unsigned grp);
        return (src == SRC_INSTR) || ((unit % grp) == 0);
    endfunction

endpackage

// File: rtl/icinv_admit.sv
module icinv_admit
    import icinv_pkg::*;
#(
    parameter int unsigned UNIT_W = 3,
    parameter int unsigned GROUP  = 4
) (
    input  logic              src,
    input  logic [UNIT_W-1:0] unit,
    output logic              needs_walk
);
    generate
        if (GROUP <= 1) begin : g_all_leaders
            assign needs_walk = 1'b1;
        end else begin : g_grouped
            assign needs_walk = walk_needed(src, 32'(unit), GROUP);
        end
    endgenerate
endmodule

// File: rtl/icinv_walk_ctrl.sv
module icinv_walk_ctrl
    import icinv_pkg::*;
#(
    parameter int NB   = 16,
    parameter int ID_W = 4,
    localparam int IDX_W  = (NB > 1) ? $clog2(NB) : 1,
    localparam int PEND_W = $clog2(NB + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ID_W-1:0]  start_id,
    input  logic             start_src,
    input  logic             ev_ready,
    input  logic             ev_done,
    input  logic             rsp_ready,
    output logic             idle,
    output logic             ev_valid,
    output logic [IDX_W-1:0] ev_idx,
    output logic             rsp_valid,
    output logic [ID_W-1:0]  rsp_id,
    output logic             rsp_src
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

    walk_st_e          st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PEND_W-1:0] pend_q;
    logic [ID_W-1:0]   id_q;
    logic              src_q;
    logic              issue_fire;

    always_comb begin
        issue_fire = (st_q == WK_ISSUE) && ev_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WK_IDLE;
            idx_q  <= '0;
            pend_q <= '0;
            id_q   <= '0;
            src_q  <= SRC_LAUNCH;
        end else begin
            pend_q <= pend_q + PEND_W'(issue_fire) - PEND_W'(ev_done);
            case (st_q)
                WK_IDLE: begin
                    if (start) begin
                        st_q  <= WK_ISSUE;
                        idx_q <= '0;
                        id_q  <= start_id;
                        src_q <= start_src;
                    end
                end
                WK_ISSUE: begin
                    if (issue_fire) begin
                        if (idx_q == LAST_IDX) begin
                            st_q <= WK_DRAIN;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                WK_DRAIN: begin
                    if (pend_q == '0) begin
                        st_q <= WK_REPLY;
                    end
                end
                WK_REPLY: begin
                    if (rsp_ready) begin
                        st_q <= WK_IDLE;
                    end
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    assign idle      = (st_q == WK_IDLE);
    assign ev_valid  = (st_q == WK_ISSUE);
    assign ev_idx    = idx_q;
    assign rsp_valid = (st_q == WK_REPLY);
    assign rsp_id    = id_q;
    assign rsp_src   = src_q;
endmodule

// File: rtl/icinv_line_array.sv
module icinv_line_array
    import icinv_pkg::*;
#(
    parameter int NB = 16,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evict,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             fill,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             look,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [IDX_W-1:0] query_idx,
    output logic [1:0]       query_state,
    output logic             hit,
    output logic             miss,
    output logic [2*NB-1:0]  line_vec
);
    logic [1:0] st_vec [NB];
    logic       hit_q;
    logic       miss_q;

    generate
        for (genvar i = 0; i < NB; i++) begin : g_line
            line_st_e line_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    line_q <= LN_INV;
                end else if (evict && (evict_idx == IDX_W'(i))) begin
                    line_q <= LN_INV;
                end else if (fill && (fill_idx == IDX_W'(i)) && (line_q == LN_FILL)) begin
                    line_q <= LN_VALID;
                end else if (look && (look_idx == IDX_W'(i)) && (line_q == LN_INV)) begin
                    line_q <= LN_FILL;
                end
            end
            assign st_vec[i]         = line_q;
            assign line_vec[2*i +: 2] = line_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            hit_q  <= look && (st_vec[look_idx] == LN_VALID);
            miss_q <= look && (st_vec[look_idx] != LN_VALID);
        end
    end

    assign hit         = hit_q;
    assign miss        = miss_q;
    assign query_state = st_vec[query_idx];
endmodule

// File: rtl/icinv_walker.sv
module icinv_walker
    import icinv_pkg::*;
#(
    parameter int NUM_BLOCKS      = 16,
    parameter int NUM_UNITS       = 8,
    parameter int UNITS_PER_GROUP = 4,
    parameter int ID_W            = 4,
    localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_req_valid,
    output logic              inv_req_ready,
    input  logic              inv_req_src,
    input  logic [UNIT_W-1:0] inv_req_unit,
    input  logic [ID_W-1:0]   inv_req_id,
    output logic              inv_rsp_valid,
    input  logic              inv_rsp_ready,
    output logic [ID_W-1:0]   inv_rsp_id,
    output logic              inv_rsp_src,
    output logic              ev_issue_valid,
    input  logic              ev_issue_ready,
    output logic [IDX_W-1:0]  ev_issue_idx,
    input  logic              ev_done_valid,
    input  logic [IDX_W-1:0]  ev_done_idx,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [IDX_W-1:0]  fetch_idx,
    output logic              fetch_hit,
    output logic              fetch_miss,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [IDX_W-1:0]  query_idx,
    output logic [1:0]        query_state
);
    logic                    idle;
    logic                    needs_walk;
    logic                    start;
    logic                    look;
    logic [2*NUM_BLOCKS-1:0] line_vec;

    icinv_admit #(
        .UNIT_W (UNIT_W),
        .GROUP  (UNITS_PER_GROUP)
    ) u_admit (
        .src        (inv_req_src),
        .unit       (inv_req_unit),
        .needs_walk (needs_walk)
    );

    assign inv_req_ready = idle;
    assign start         = inv_req_valid && idle && needs_walk;
    assign fetch_ready   = idle;
    assign look          = fetch_valid && idle;

    icinv_walk_ctrl #(
        .NB   (NUM_BLOCKS),
        .ID_W (ID_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_id  (inv_req_id),
        .start_src (inv_req_src),
        .ev_ready  (ev_issue_ready),
        .ev_done   (ev_done_valid),
        .rsp_ready (inv_rsp_ready),
        .idle      (idle),
        .ev_valid  (ev_issue_valid),
        .ev_idx    (ev_issue_idx),
        .rsp_valid (inv_rsp_valid),
        .rsp_id    (inv_rsp_id),
        .rsp_src   (inv_rsp_src)
    );

    icinv_line_array #(
        .NB (NUM_BLOCKS)
    ) u_lines (
        .clk         (clk),
        .rst         (rst),
        .evict       (ev_done_valid),
        .evict_idx   (ev_done_idx),
        .fill        (fill_valid),
        .fill_idx    (fill_idx),
        .look        (look),
        .look_idx    (fetch_idx),
        .query_idx   (query_idx),
        .query_state (query_state),
        .hit         (fetch_hit),
        .miss        (fetch_miss),
        .line_vec    (line_vec)
    );
endmodule

// File: rtl/icinv_walker_chk.sv
module icinv_walker_chk #(
    parameter int NB    = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             inv_req_ready,
    input logic             inv_rsp_valid,
    input logic             inv_rsp_ready,
    input logic [3:0]       inv_rsp_id,
    input logic             ev_issue_valid,
    input logic             ev_issue_ready,
    input logic [IDX_W-1:0] ev_issue_idx,
    input logic             ev_done_valid,
    input logic [IDX_W-1:0] ev_done_idx,
    input logic             fetch_valid,
    input logic             fetch_ready,
    input logic             fetch_hit,
    input logic             fetch_miss,
    input logic [2*NB-1:0]  line_vec
);
    logic             done_d;
    logic [IDX_W-1:0] done_idx_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_d     <= 1'b0;
            done_idx_d <= '0;
        end else begin
            done_d     <= ev_done_valid;
            done_idx_d <= ev_done_idx;
        end
    end

    // R2
    rsp_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
        inv_rsp_valid |-> !inv_req_ready);

    // R7
    walk_blocks_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ev_issue_valid |-> !fetch_ready);

    // R3
    walk_starts_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_issue_valid) |-> (ev_issue_idx == '0));

    // R3
    walk_steps_one_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ev_issue_valid && ev_issue_ready) && ev_issue_valid)
            |-> (ev_issue_idx == $past(ev_issue_idx) + 1'b1));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_issue_valid && !ev_issue_ready) |=> (ev_issue_valid && $stable(ev_issue_idx)));

    // R5
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_rsp_valid && !inv_rsp_ready) |=> (inv_rsp_valid && $stable(inv_rsp_id)));

    // R5
    rsp_after_walk_chk: assert property (@(posedge clk) disable iff (rst)
        inv_rsp_valid |-> !ev_issue_valid);

    // R6
    evict_clears_chk: assert property (@(posedge clk) disable iff (rst)
        done_d |-> (line_vec[2*done_idx_d +: 2] == 2'b00));

    // R8
    pulse_from_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_hit || fetch_miss) |-> $past(fetch_valid && fetch_ready));

    // R8
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_hit && fetch_miss));
endmodule

bind icinv_walker icinv_walker_chk #(
    .NB    (NUM_BLOCKS),
    .IDX_W (IDX_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .inv_req_ready  (inv_req_ready),
    .inv_rsp_valid  (inv_rsp_valid),
    .inv_rsp_ready  (inv_rsp_ready),
    .inv_rsp_id     (inv_rsp_id),
    .ev_issue_valid (ev_issue_valid),
    .ev_issue_ready (ev_issue_ready),
    .ev_issue_idx   (ev_issue_idx),
    .ev_done_valid  (ev_done_valid),
    .ev_done_idx    (ev_done_idx),
    .fetch_valid    (fetch_valid),
    .fetch_ready    (fetch_ready),
    .fetch_hit      (fetch_hit),
    .fetch_miss     (fetch_miss),
    .line_vec       (line_vec)
);

// File: tb/icinv_walker_bench.sv
module icinv_walker_bench;
    localparam int NB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_v = 1'b0, req_src = 1'b0, rsp_rdy = 1'b0;
    logic [2:0] req_unit = '0;
    logic [3:0] req_id = '0;
    logic       evr = 1'b0, dv = 1'b0, fv = 1'b0, filv = 1'b0;
    logic [3:0] didx = '0, fidx = '0, filidx = '0, qidx = '0;

    logic       inv_req_ready, inv_rsp_valid, inv_rsp_src;
    logic [3:0] inv_rsp_id;
    logic       ev_issue_valid;
    logic [3:0] ev_issue_idx;
    logic       fetch_ready, fetch_hit, fetch_miss;
    logic [1:0] query_state;

    always #10 clk = ~clk;

    icinv_walker u_icinv_walker (
        .clk(clk), .rst(rst),
        .inv_req_valid(req_v), .inv_req_ready(inv_req_ready),
        .inv_req_src(req_src), .inv_req_unit(req_unit), .inv_req_id(req_id),
        .inv_rsp_valid(inv_rsp_valid), .inv_rsp_ready(rsp_rdy),
        .inv_rsp_id(inv_rsp_id), .inv_rsp_src(inv_rsp_src),
        .ev_issue_valid(ev_issue_valid), .ev_issue_ready(evr),
        .ev_issue_idx(ev_issue_idx),
        .ev_done_valid(dv), .ev_done_idx(didx),
        .fetch_valid(fv), .fetch_ready(fetch_ready), .fetch_idx(fidx),
        .fetch_hit(fetch_hit), .fetch_miss(fetch_miss),
        .fill_valid(filv), .fill_idx(filidx),
        .query_idx(qidx), .query_state(query_state)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rdy_period = 1;
    int done_period = 1;
    int evq[$];

    // reference model
    int m_line [NB];
    bit m_busy = 0, m_issuing = 0, m_rsp_on = 0, m_arm = 0, m_hit = 0, m_miss = 0;
    int m_next = 0, m_out = 0, m_id = 0, m_src = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        int nl [NB];
        bit fetch_fire;
        @(negedge clk);
        evr = ((cyc % rdy_period) == 0);
        dv  = 1'b0;
        if (evq.size() > 0 && (cyc % done_period) == 0) begin
            dv   = 1'b1;
            didx = 4'(evq[0]);
        end
        qidx = 4'(cyc % NB);
        #1;
        chk(inv_req_ready == !m_busy, "R2", int'(inv_req_ready), int'(!m_busy));
        chk(fetch_ready == !m_busy, "R7", int'(fetch_ready), int'(!m_busy));
        chk(ev_issue_valid == m_issuing, "R3", int'(ev_issue_valid), int'(m_issuing));
        if (ev_issue_valid && m_issuing)
            chk(int'(ev_issue_idx) == m_next, "R4", int'(ev_issue_idx), m_next);
        chk(inv_rsp_valid == m_rsp_on, "R5", int'(inv_rsp_valid), int'(m_rsp_on));
        if (inv_rsp_valid && m_rsp_on) begin
            chk(int'(inv_rsp_id) == m_id, "R5", int'(inv_rsp_id), m_id);
            chk(int'(inv_rsp_src) == m_src, "R5", int'(inv_rsp_src), m_src);
        end
        chk(int'(query_state) == m_line[qidx], "R6", int'(query_state), m_line[qidx]);
        chk(fetch_hit == m_hit, "R8", int'(fetch_hit), int'(m_hit));
        chk(fetch_miss == m_miss, "R8", int'(fetch_miss), int'(m_miss));

        // model update for the coming edge
        fetch_fire = fv && !m_busy;
        m_hit  = fetch_fire && (m_line[fidx] == 2);
        m_miss = fetch_fire && (m_line[fidx] != 2);
        for (int i = 0; i < NB; i++) nl[i] = m_line[i];
        if (fetch_fire && m_line[fidx] == 0) nl[fidx] = 1;
        if (filv && m_line[filidx] == 1) nl[filidx] = 2;
        if (dv) nl[didx] = 0;
        for (int i = 0; i < NB; i++) m_line[i] = nl[i];

        if (m_arm) begin
            m_rsp_on = 1;
            m_arm = 0;
        end else if (m_rsp_on && rsp_rdy) begin
            m_rsp_on = 0;
            m_busy = 0;
        end
        if (m_issuing && evr) begin
            evq.push_back(m_next);
            m_out++;
            m_next++;
            if (m_next == NB) m_issuing = 0;
        end
        if (dv) begin
            void'(evq.pop_front());
            m_out--;
            if (m_out == 0 && !m_issuing && m_next == NB && m_busy) m_arm = 1;
        end
        if (req_v && !m_busy && (req_src || (int'(req_unit) % 4) == 0)) begin
            m_busy = 1; m_issuing = 1; m_next = 0; m_out = 0;
            m_id = int'(req_id); m_src = int'(req_src);
        end
        cyc++;
        @(posedge clk);
        #1;
    endtask

    task automatic send_req(input bit src, input int unit, input int id);
        req_v = 1'b1; req_src = src; req_unit = 3'(unit); req_id = 4'(id);
        tick();
        req_v = 1'b0;
    endtask

    task automatic do_fetch(input int idx);
        fv = 1'b1; fidx = 4'(idx);
        tick();
        fv = 1'b0;
    endtask

    task automatic do_fill(input int idx);
        filv = 1'b1; filidx = 4'(idx);
        tick();
        filv = 1'b0;
    endtask

    task automatic finish_walk(input int hold);
        int n = 0;
        while (!m_rsp_on && n < 2000) begin tick(); n++; end
        repeat (hold) tick();
        rsp_rdy = 1'b1;
        tick();
        rsp_rdy = 1'b0;
        tick();
    endtask

    initial begin
        for (int i = 0; i < NB; i++) m_line[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(inv_req_ready == 1'b1, "R1", int'(inv_req_ready), 1);
        chk(fetch_ready == 1'b1, "R1", int'(fetch_ready), 1);
        chk(ev_issue_valid == 1'b0, "R1", int'(ev_issue_valid), 0);
        chk(inv_rsp_valid == 1'b0, "R1", int'(inv_rsp_valid), 0);
        repeat (NB) tick();

        // R8 lookups and fills
        do_fetch(3); do_fill(3); do_fetch(3);
        do_fetch(5); do_fill(9); do_fetch(7); do_fill(7);
        tick(); tick();

        // R2 R3 R5 R7: instruction invalidate, prompt controller
        send_req(1'b1, 2, 9);
        do_fetch(1);
        finish_walk(3);
        repeat (NB) tick();

        // R9: non-leader launch dropped
        send_req(1'b0, 1, 4);
        chk(ev_issue_valid == 1'b0, "R9", int'(ev_issue_valid), 0);
        chk(inv_req_ready == 1'b1, "R9", int'(inv_req_ready), 1);
        repeat (4) tick();
        chk(ev_issue_valid == 1'b0, "R9", int'(ev_issue_valid), 0);

        // R4 R6: leader launch, slow controller, fill during walk
        do_fetch(3); do_fill(3); do_fetch(5); do_fetch(3);
        rdy_period = 3; done_period = 4;
        send_req(1'b0, 4, 6);
        tick(); do_fill(5); do_fill(12);
        finish_walk(0);
        rdy_period = 1; done_period = 1;
        repeat (2 * NB) tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule